// File: doc/BRIEF.md
# Vector Zero-Test Branch Evaluator

This block resolves the outcome of a vector zero-test conditional branch. It receives a vector register value together with the 5-bit operation field of the branch, the address of the branch and its 16-bit word offset. From these it decides whether the branch is taken and produces the address of the next instruction to run. It supports two families of condition. The per-element family treats the vector as packed elements of 1, 2, 4 or 8 bytes and asks whether some element is entirely zero. The whole-vector family ignores element format and asks whether the full vector is zero. Each family also has an inverted sense.

Operands enter on a valid/ready stream. Results leave on a second valid/ready stream held in a single output register. An accepted operand set gives a result in the following cycle. While the consumer holds `res_ready` low, the result stays frozen and `op_ready` is low. `op_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-to-back operands flow at one per cycle. When `res_ready` is low, the producer must hold its operands until it sees `op_ready`.

Top module: `vzb_eval`

## Requirements
- R1: When op bits [4:3] are 2'b11 and op bit 2 is 0, the branch is taken if at least one aligned element of (1 << op[1:0]) bytes (00 byte, 01 halfword, 10 word, 11 doubleword; element 0 at the least significant end) has all bits zero.
- R2: When op bits [4:3] are 2'b11 and op bit 2 is 1, the branch is taken exactly when the R1 condition is false, that is when every element of the selected size has at least one bit set.
- R3: When op is 5'b01011, the branch is taken only if every bit of the vector is zero.
- R4: When op is 5'b01111, the branch is taken if any bit of the vector is set.
- R5: Any op value that matches neither (op[4:3] == 2'b11) nor ((op & 5'b11011) == 5'b01011) sets `res_invalid` high, forces `res_taken` low and gives the not-taken address. For valid op values `res_invalid` is low.
- R6: A taken branch gives `res_next_pc` = branch address + 4 + (sign-extended 16-bit offset shifted left by 2), modulo 2^32.
- R7: A branch that is not taken gives `res_next_pc` = branch address + 8.
- R8: An operand set accepted on a rising edge (`op_valid` and `op_ready` both high) makes `res_valid` high after that edge, carrying that operand set's result. `res_valid` then drops after the next edge at which `res_ready` is high and no new operand set is accepted.
- R9: While `res_valid` is high and `res_ready` is low, `op_ready` is low and all result outputs hold their values.
- R10: After reset `res_valid` is low and `op_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand set is present |
| op_ready | output | 1 | Block can accept an operand set this cycle |
| op_vec | input | VEC_W | Vector register value |
| op_code | input | 5 | Branch operation field |
| op_pc | input | PC_W | Address of the branch instruction |
| op_imm | input | IMM_W | Signed word offset of the branch |
| res_valid | output | 1 | Result is present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_taken | output | 1 | Branch is taken |
| res_invalid | output | 1 | Op field is not a vector zero-test branch |
| res_next_pc | output | PC_W | Address of the next instruction |

## Verification
The bench builds the block with its defaults: a 128-bit vector, a 32-bit address and a 16-bit offset. At this size every one of the 32 op codes can be swept against a set of vectors. The set contains the all-zero vector and a dense non-zero vector. It also has a zero byte at each of the 16 positions, and zeroed halfwords, words and doublewords at the first and last aligned slots. Zeroed runs that straddle element boundaries and single set bits at both ends and in the middle complete it, so each element size meets both a near-miss and a hit. Offsets at the positive and negative extremes exercise the sign extension of the target adder. A separate stall sequence holds `res_ready` low to check that the result freezes and that a waiting operand set is taken only after the drain.

// File: rtl/vzb_pkg.sv
package vzb_pkg;

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_ELEM  = 2'd1,
    GRP_WHOLE = 2'd2
  } vzb_grp_e;

  typedef struct packed {
    vzb_grp_e   grp;
    logic       inv;
    logic [1:0] fmt;
  } vzb_dec_t;

  localparam int OP_W       = 5;
  localparam int NUM_FMT    = 4;
  localparam int INSN_BYTES = 4;

endpackage

// File: rtl/vzb_decode.sv
module vzb_decode
  import vzb_pkg::*;
(
  input  logic [OP_W-1:0] code,
  output vzb_dec_t        dec,
  output logic            bad
);
  logic is_elem, is_whole;

  always_comb begin
    is_elem  = (code[4:3] == 2'b11);
    is_whole = ((code & 5'b11011) == 5'b01011);
    dec.inv  = code[2];
    dec.fmt  = code[1:0];
    if (is_elem)       dec.grp = GRP_ELEM;
    else if (is_whole) dec.grp = GRP_WHOLE;
    else               dec.grp = GRP_NONE;
    bad = !(is_elem || is_whole);
  end
endmodule

// File: rtl/vzb_zero_detect.sv
module vzb_zero_detect
  import vzb_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]   vec,
  output logic [NUM_FMT-1:0] fmt_has_zero,
  output logic               all_zero
);
  localparam int NBYTES = VEC_W / 8;

  logic [NBYTES-1:0] byte_nz;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign byte_nz[b] = |vec[8*b +: 8];
  end

  for (genvar s = 0; s < NUM_FMT; s++) begin : g_fmt
    localparam int EB = 1 << s;
    localparam int NE = NBYTES / EB;
    logic [NE-1:0] elem_zero;
    for (genvar e = 0; e < NE; e++) begin : g_elem
      assign elem_zero[e] = ~|byte_nz[e*EB +: EB];
    end
    assign fmt_has_zero[s] = |elem_zero;
  end

  assign all_zero = ~|byte_nz;
endmodule

// File: rtl/vzb_target.sv
module vzb_target
  import vzb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IMM_W = 16
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  input  logic             taken,
  output logic [PC_W-1:0]  next_pc
);
  localparam int EXT_W = PC_W - IMM_W - 2;

  logic [PC_W-1:0] follow, offset, step;

  always_comb begin
    follow  = pc + PC_W'(INSN_BYTES);
    offset  = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    step    = taken ? offset : PC_W'(INSN_BYTES);
    next_pc = follow + step;
  end
endmodule

// File: rtl/vzb_eval.sv
module vzb_eval
  import vzb_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int PC_W  = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [VEC_W-1:0] op_vec,
  input  logic [OP_W-1:0]  op_code,
  input  logic [PC_W-1:0]  op_pc,
  input  logic [IMM_W-1:0] op_imm,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_taken,
  output logic             res_invalid,
  output logic [PC_W-1:0]  res_next_pc
);
  vzb_dec_t           dec;
  logic               bad;
  logic [NUM_FMT-1:0] fmt_has_zero;
  logic               all_zero;
  logic               taken_c;
  logic [PC_W-1:0]    next_pc_c;
  logic               accept;

  vzb_decode u_dec (
    .code (op_code),
    .dec  (dec),
    .bad  (bad)
  );

  vzb_zero_detect #(.VEC_W(VEC_W)) u_zd (
    .vec          (op_vec),
    .fmt_has_zero (fmt_has_zero),
    .all_zero     (all_zero)
  );

  always_comb begin
    unique case (dec.grp)
      GRP_ELEM:  taken_c = fmt_has_zero[dec.fmt] ^ dec.inv;
      GRP_WHOLE: taken_c = all_zero ^ dec.inv;
      default:   taken_c = 1'b0;
    endcase
  end

  vzb_target #(.PC_W(PC_W), .IMM_W(IMM_W)) u_tgt (
    .pc      (op_pc),
    .imm     (op_imm),
    .taken   (taken_c),
    .next_pc (next_pc_c)
  );

  assign op_ready = !res_valid || res_ready;
  assign accept   = op_valid && op_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_invalid <= 1'b0;
      res_next_pc <= '0;
    end else if (accept) begin
      res_valid   <= 1'b1;
      res_taken   <= taken_c;
      res_invalid <= bad;
      res_next_pc <= next_pc_c;
    end else if (res_ready) begin
      res_valid   <= 1'b0;
    end
  end

  AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_taken)
      && $stable(res_invalid) && $stable(res_next_pc))); // R9
  AST_INVALID_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_invalid) |-> !res_taken); // R5
  AST_ZERO_VEC_ALL_FMTS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && all_zero) |-> (&fmt_has_zero)); // R3
  AST_WIDER_ZERO_NESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && fmt_has_zero[3]) |-> (fmt_has_zero[2] && fmt_has_zero[1]
      && fmt_has_zero[0])); // R1
endmodule

// File: tb/tb_vzb_eval.sv
`timescale 1ns/1ps
module tb_vzb_eval;
  localparam int VEC_W = 128;
  localparam int PC_W  = 32;
  localparam int IMM_W = 16;
  localparam int NB    = VEC_W / 8;
  localparam int NVEC  = 30;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             op_valid = 1'b0;
  logic             op_ready;
  logic [VEC_W-1:0] op_vec = '0;
  logic [4:0]       op_code = '0;
  logic [PC_W-1:0]  op_pc = '0;
  logic [IMM_W-1:0] op_imm = '0;
  logic             res_valid;
  logic             res_ready = 1'b1;
  logic             res_taken;
  logic             res_invalid;
  logic [PC_W-1:0]  res_next_pc;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  vzb_eval #(.VEC_W(VEC_W), .PC_W(PC_W), .IMM_W(IMM_W)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_vec(op_vec), .op_code(op_code), .op_pc(op_pc), .op_imm(op_imm),
    .res_valid(res_valid), .res_ready(res_ready), .res_taken(res_taken),
    .res_invalid(res_invalid), .res_next_pc(res_next_pc)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [VEC_W-1:0] filler();
    logic [VEC_W-1:0] v;
    for (int b = 0; b < NB; b++) v[8*b +: 8] = 8'h80 | 8'(b);
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] zero_run(input int start, input int len);
    logic [VEC_W-1:0] v = filler();
    for (int b = start; b < start + len; b++) v[8*b +: 8] = 8'h00;
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] pick_vec(input int k);
    logic [VEC_W-1:0] v;
    if (k == 0) v = '0;
    else if (k == 1) v = filler();
    else if (k < 18) v = zero_run(k - 2, 1);
    else if (k == 18) v = zero_run(0, 2);
    else if (k == 19) v = zero_run(NB - 2, 2);
    else if (k == 20) v = zero_run(0, 4);
    else if (k == 21) v = zero_run(NB - 4, 4);
    else if (k == 22) v = zero_run(0, 8);
    else if (k == 23) v = zero_run(NB - 8, 8);
    else if (k == 24) v = zero_run(1, 2);
    else if (k == 25) v = zero_run(2, 4);
    else if (k == 26) v = zero_run(4, 8);
    else begin
      v = '0;
      if (k == 27) v[0] = 1'b1;
      else if (k == 28) v[VEC_W-1] = 1'b1;
      else v[VEC_W/2] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic has_zero_elem(input logic [VEC_W-1:0] v, input int fmt);
    int eb = 1 << fmt;
    for (int e = 0; e < NB / eb; e++) begin
      logic z = 1'b1;
      for (int b = 0; b < eb; b++)
        if (v[8*(e*eb + b) +: 8] != 8'h00) z = 1'b0;
      if (z) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic run_one(input logic [VEC_W-1:0] v, input logic [4:0] c,
                         input logic [PC_W-1:0] pc, input logic [IMM_W-1:0] imm);
    logic elem, whole, inv, exp_t, exp_bad;
    logic [PC_W-1:0] exp_pc, offs;
    string tag;
    elem  = (c[4:3] == 2'b11);
    whole = (c[4] == 1'b0) && (c[3] == 1'b1) && (c[1:0] == 2'b11);
    inv   = c[2];
    exp_bad = !(elem || whole);
    if (elem) begin
      exp_t = has_zero_elem(v, int'(c[1:0])) ^ inv;
      tag = inv ? "R2 elem-nonzero" : "R1 elem-zero";
    end else if (whole) begin
      exp_t = (v == '0) ^ inv;
      tag = inv ? "R4 whole-nonzero" : "R3 whole-zero";
    end else begin
      exp_t = 1'b0;
      tag = "R5 invalid-op";
    end
    offs   = PC_W'($signed(imm)) << 2;
    exp_pc = exp_t ? (pc + 32'd4 + offs) : (pc + 32'd8);
    op_vec = v; op_code = c; op_pc = pc; op_imm = imm; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check("R8 result valid after accept", 64'(res_valid), 64'd1);
    check(tag, 64'(res_taken), 64'(exp_t));
    check("R5 invalid flag", 64'(res_invalid), 64'(exp_bad));
    check(exp_t ? "R6 taken target" : "R7 fall-through", 64'(res_next_pc), 64'(exp_pc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [IMM_W-1:0] imms [4];
    int cnt;
    imms[0] = 16'h7FFF; imms[1] = 16'h8000; imms[2] = 16'h0001; imms[3] = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R10 reset res_valid", 64'(res_valid), 64'd0);
    check("R10 reset op_ready", 64'(op_ready), 64'd1);

    cnt = 0;
    for (int k = 0; k < NVEC; k++) begin
      for (int c = 0; c < 32; c++) begin
        run_one(pick_vec(k), 5'(c), 32'h1000_0000 + 32'(cnt * 4), imms[cnt % 4]);
        cnt++;
      end
    end

    @(posedge clk);
    @(negedge clk);
    check("R8 result drains", 64'(res_valid), 64'd0);

    // R9 stall: result A must freeze while a second operand set waits
    res_ready = 1'b0;
    run_one('0, 5'b01011, 32'h0000_4000, 16'h0010);
    op_vec = filler(); op_code = 5'b01011; op_pc = 32'h0000_8000; op_imm = 16'h0000;
    op_valid = 1'b1;
    check("R9 op_ready low under stall", 64'(op_ready), 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R9 held valid", 64'(res_valid), 64'd1);
    check("R9 held taken", 64'(res_taken), 64'd1);
    check("R9 held next pc", 64'(res_next_pc), 64'h0000_4044);
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check("R9 second result taken flag", 64'(res_taken), 64'd0);
    check("R9 second result next pc", 64'(res_next_pc), 64'h0000_8008);
    @(posedge clk);
    @(negedge clk);
    check("R8 drained after stall", 64'(res_valid), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule